// File: doc/BRIEF.md
# Register-Direct and Immediate Execute Unit

This block holds a 32-entry, 8-bit general-purpose register file and a one-cycle execute stage for a small set of 16-bit instruction words. When `instr_valid` is high, the instruction on `instr` is decoded, its operands are read from the register file, and the result is written back on the same clock edge. The carry and zero flags are updated on that edge too.

The supported forms are:
- single-register rotate-left-through-carry and one's complement;
- two-register add and bitwise AND;
- byte-immediate load and OR, which can reach only the upper sixteen registers;
- a word add-immediate on one of four even register pairs.

A registered debug read port returns the contents of any register, one cycle after its address is presented.

The unit is meant to sit behind a fetch stage that supplies one word per cycle. Words that match no supported pattern pass through without side effects. No stall or handshake is needed: every recognised word retires in the cycle it is accepted.

Top module: `imm_exec_unit`

## Requirements
- R1: After synchronous reset `rst`, all 32 registers read 0, `carry_flag` is 0, `zero_flag` is 0, and `dbg_data` is 0.
- R2: Add is encoded `0000 11rd dddd rrrr` and AND is encoded `0010 00rd dddd rrrr`. Here d = {bit8, bits7:4} and r = {bit9, bits3:0}. Each writes Rd op Rr into Rd. Add sets carry to the carry out of bit 7. AND leaves carry unchanged. Both set zero when the 8-bit result is 0.
- R3: The single-register forms have d in bits 8:4. Complement is encoded `1001 010d dddd 0000`; it writes ~Rd, sets carry to 1, and sets zero if the result is 0. Rotate is encoded `1001 010d dddd 0111`; it writes {Rd[6:0], carry}, sets carry to the old Rd[7], and sets zero if the result is 0.
- R4: Load-immediate is encoded `1110 KKKK dddd KKKK` and OR-immediate is encoded `0110 KKKK dddd KKKK`. The high K nibble is bits 11:8, the low K nibble is bits 3:0, and the target is register 16 + bits 7:4.
- R5: Load-immediate changes neither flag. OR-immediate sets zero when the result is 0 and leaves carry unchanged.
- R6: Word add-immediate is encoded `1001 0110 KKpp KKKK`. Bits 7:6 are K[5:4], bits 5:4 are p, and bits 3:0 are K[3:0]. It adds the 6-bit K to the 16-bit value {R(24+2p+1), R(24+2p)} and writes both bytes in the same cycle. Carry is the carry out of bit 15, and zero is set when all 16 result bits are 0.
- R7: An accepted word matching none of the patterns above changes no register and neither flag.
- R8: While `instr_valid` is low, no register and neither flag changes, whatever `instr` holds.
- R9: `dbg_data` shows the register at `dbg_addr` one cycle after the address is presented. If that register is written on the same edge, the old value is returned on that cycle and the new value on the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 16 | Instruction word |
| dbg_addr | input | 5 | Debug read register index |
| dbg_data | output | 8 | Registered debug read data |
| carry_flag | output | 1 | Carry flag |
| zero_flag | output | 1 | Zero flag |

## Verification
Two things can happen on the same edge: a write-back from the execute stage and a debug read of the very register being written. The bench provokes this by issuing a load-immediate to R20 while `dbg_addr` is already 20. It expects the pre-write value on the first cycle and the loaded constant on the next. The word add is a second same-edge case, because it writes two registers in one cycle. Each pair is read back after every add, across carry-in patterns from zero up to the 0xFFFF wrap.

// File: rtl/imm_exec_pkg.sv
package imm_exec_pkg;
  localparam int DATA_W   = 8;
  localparam int REG_N    = 32;
  localparam int ADDR_W   = $clog2(REG_N);
  localparam int WORD_W   = 2 * DATA_W;
  localparam int KW_W     = 6;
  localparam int PAIR_BASE = 24;

  typedef enum logic [2:0] {
    OP_NONE, OP_ROL, OP_COM, OP_ADD, OP_AND, OP_LDI, OP_ORI, OP_ADIW
  } op_e;

  typedef struct packed {
    op_e               op;
    logic [ADDR_W-1:0] rd;
    logic [ADDR_W-1:0] rr;
    logic [DATA_W-1:0] k;
  } dec_t;
endpackage

// File: rtl/imm_decode.sv
module imm_decode
  import imm_exec_pkg::*;
(
  input  logic [15:0] instr,
  output dec_t        dec
);
  logic [ADDR_W-1:0] pair_lo;

  always_comb begin
    pair_lo = ADDR_W'(PAIR_BASE + 2 * int'(instr[5:4]));
    dec     = '0;
    dec.op  = OP_NONE;
    if (instr[15:10] == 6'b000011) begin
      dec.op = OP_ADD;
      dec.rd = instr[8:4];
      dec.rr = {instr[9], instr[3:0]};
    end else if (instr[15:10] == 6'b001000) begin
      dec.op = OP_AND;
      dec.rd = instr[8:4];
      dec.rr = {instr[9], instr[3:0]};
    end else if (instr[15:12] == 4'b1110 || instr[15:12] == 4'b0110) begin
      dec.op = (instr[15]) ? OP_LDI : OP_ORI;
      dec.rd = {1'b1, instr[7:4]};
      dec.k  = {instr[11:8], instr[3:0]};
    end else if (instr[15:9] == 7'b1001010 && instr[3:0] == 4'h0) begin
      dec.op = OP_COM;
      dec.rd = instr[8:4];
    end else if (instr[15:9] == 7'b1001010 && instr[3:0] == 4'h7) begin
      dec.op = OP_ROL;
      dec.rd = instr[8:4];
    end else if (instr[15:8] == 8'h96) begin
      dec.op = OP_ADIW;
      dec.rd = pair_lo;
      dec.k  = DATA_W'({instr[7:6], instr[3:0]});
    end
  end

  // R4
  always_comb begin
    if (dec.op == OP_LDI || dec.op == OP_ORI)
      upper_half_chk: assert (dec.rd >= ADDR_W'(REG_N / 2));
  end
endmodule

// File: rtl/imm_alu.sv
module imm_alu
  import imm_exec_pkg::*;
(
  input  op_e               op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] a_hi,
  input  logic [DATA_W-1:0] k,
  input  logic              c_in,
  output logic [DATA_W-1:0] res_lo,
  output logic [DATA_W-1:0] res_hi,
  output logic              we_lo,
  output logic              we_hi,
  output logic              c_we,
  output logic              c_out,
  output logic              z_we,
  output logic              z_out
);
  logic [DATA_W:0] sum8;
  logic [WORD_W:0] sum16;

  always_comb begin
    sum8   = {1'b0, a} + {1'b0, b};
    sum16  = {1'b0, a_hi, a} + (WORD_W + 1)'(k[KW_W-1:0]);
    res_lo = '0;
    res_hi = '0;
    we_lo  = 1'b0;
    we_hi  = 1'b0;
    c_we   = 1'b0;
    c_out  = c_in;
    z_we   = 1'b0;
    z_out  = 1'b0;
    unique case (op)
      OP_ROL: begin
        res_lo = {a[DATA_W-2:0], c_in};
        we_lo = 1'b1; c_we = 1'b1; c_out = a[DATA_W-1]; z_we = 1'b1;
      end
      OP_COM: begin
        res_lo = ~a;
        we_lo = 1'b1; c_we = 1'b1; c_out = 1'b1; z_we = 1'b1;
      end
      OP_ADD: begin
        res_lo = sum8[DATA_W-1:0];
        we_lo = 1'b1; c_we = 1'b1; c_out = sum8[DATA_W]; z_we = 1'b1;
      end
      OP_AND: begin
        res_lo = a & b;
        we_lo = 1'b1; z_we = 1'b1;
      end
      OP_LDI: begin
        res_lo = k;
        we_lo = 1'b1;
      end
      OP_ORI: begin
        res_lo = a | k;
        we_lo = 1'b1; z_we = 1'b1;
      end
      OP_ADIW: begin
        res_lo = sum16[DATA_W-1:0];
        res_hi = sum16[WORD_W-1:DATA_W];
        we_lo = 1'b1; we_hi = 1'b1;
        c_we = 1'b1; c_out = sum16[WORD_W]; z_we = 1'b1;
      end
      default: ;
    endcase
    if (op == OP_ADIW) z_out = ({res_hi, res_lo} == '0);
    else               z_out = (res_lo == '0);
  end
endmodule

// File: rtl/imm_regfile.sv
module imm_regfile
  import imm_exec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ra_a,
  input  logic [ADDR_W-1:0] ra_b,
  input  logic [ADDR_W-1:0] ra_c,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b,
  output logic [DATA_W-1:0] rd_c,
  input  logic              we_lo,
  input  logic [ADDR_W-1:0] wa_lo,
  input  logic [DATA_W-1:0] wd_lo,
  input  logic              we_hi,
  input  logic [ADDR_W-1:0] wa_hi,
  input  logic [DATA_W-1:0] wd_hi,
  input  logic [ADDR_W-1:0] dbg_addr,
  output logic [DATA_W-1:0] dbg_data
);
  logic [DATA_W-1:0] mem [REG_N];

  assign rd_a = mem[ra_a];
  assign rd_b = mem[ra_b];
  assign rd_c = mem[ra_c];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REG_N; i++) mem[i] <= '0;
      dbg_data <= '0;
    end else begin
      dbg_data <= mem[dbg_addr];
      if (we_lo) mem[wa_lo] <= wd_lo;
      if (we_hi) mem[wa_hi] <= wd_hi;
    end
  end

  // R6
  pair_write_chk: assert property (@(posedge clk) disable iff (rst)
    we_hi |-> (we_lo && wa_hi == wa_lo + 1'b1 && !wa_lo[0]
               && wa_lo >= ADDR_W'(PAIR_BASE)));
endmodule

// File: rtl/imm_exec_unit.sv
module imm_exec_unit
  import imm_exec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [15:0]       instr,
  input  logic [ADDR_W-1:0] dbg_addr,
  output logic [DATA_W-1:0] dbg_data,
  output logic              carry_flag,
  output logic              zero_flag
);
  dec_t              dec;
  logic [DATA_W-1:0] opa, opb, opa_hi, res_lo, res_hi;
  logic              we_lo, we_hi, c_we, c_out, z_we, z_out;
  logic [ADDR_W-1:0] rd_hi;

  assign rd_hi = {dec.rd[ADDR_W-1:1], 1'b1};

  imm_decode u_dec (.instr(instr), .dec(dec));

  imm_regfile u_rf (
    .clk(clk), .rst(rst),
    .ra_a(dec.rd), .ra_b(dec.rr), .ra_c(rd_hi),
    .rd_a(opa), .rd_b(opb), .rd_c(opa_hi),
    .we_lo(we_lo && instr_valid), .wa_lo(dec.rd), .wd_lo(res_lo),
    .we_hi(we_hi && instr_valid), .wa_hi(rd_hi), .wd_hi(res_hi),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  imm_alu u_alu (
    .op(dec.op), .a(opa), .b(opb), .a_hi(opa_hi), .k(dec.k), .c_in(carry_flag),
    .res_lo(res_lo), .res_hi(res_hi), .we_lo(we_lo), .we_hi(we_hi),
    .c_we(c_we), .c_out(c_out), .z_we(z_we), .z_out(z_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_flag <= 1'b0;
      zero_flag  <= 1'b0;
    end else if (instr_valid) begin
      if (c_we) carry_flag <= c_out;
      if (z_we) zero_flag  <= z_out;
    end
  end

  // R8
  idle_flags_chk: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> ($stable(carry_flag) && $stable(zero_flag)));

  // R3
  com_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && dec.op == OP_COM) |=> carry_flag);

  // R5
  ldi_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && dec.op == OP_LDI) |=> ($stable(carry_flag) && $stable(zero_flag)));

  // R7
  unknown_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && dec.op == OP_NONE) |=> ($stable(carry_flag) && $stable(zero_flag)));
endmodule

// File: tb/imm_exec_unit_tb.sv
`timescale 1ns/1ps
module imm_exec_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [15:0] instr = '0;
  logic [4:0]  dbg_addr = '0;
  logic [7:0]  dbg_data;
  logic        carry_flag, zero_flag;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  logic [7:0] m [32];
  logic mc, mz;

  always #2.5 clk = ~clk;

  imm_exec_unit u_dut (.clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data), .carry_flag(carry_flag), .zero_flag(zero_flag));

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic issue(logic [15:0] w, logic v = 1'b1);
    @(negedge clk);
    instr = w; instr_valid = v;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic read_reg(int a, output logic [7:0] v);
    @(negedge clk);
    dbg_addr = 5'(a);
    @(posedge clk);
    @(negedge clk);
    v = dbg_data;
  endtask

  task automatic chk_reg(string tag, int a);
    logic [7:0] v;
    read_reg(a, v);
    chk($sformatf("%s reg%0d", tag, a), v, m[a]);
  endtask

  task automatic chk_flags(string tag);
    chk({tag, " carry"}, carry_flag, mc);
    chk({tag, " zero"}, zero_flag, mz);
  endtask

  function automatic logic [15:0] e_ldi(int d, logic [7:0] k); return {4'hE, k[7:4], 4'(d - 16), k[3:0]}; endfunction
  function automatic logic [15:0] e_ori(int d, logic [7:0] k); return {4'h6, k[7:4], 4'(d - 16), k[3:0]}; endfunction
  function automatic logic [15:0] e_add(int d, int r); return {6'b000011, 1'(r >> 4), 5'(d), 4'(r)}; endfunction
  function automatic logic [15:0] e_and(int d, int r); return {6'b001000, 1'(r >> 4), 5'(d), 4'(r)}; endfunction
  function automatic logic [15:0] e_com(int d); return {7'b1001010, 5'(d), 4'h0}; endfunction
  function automatic logic [15:0] e_rol(int d); return {7'b1001010, 5'(d), 4'h7}; endfunction
  function automatic logic [15:0] e_adiw(int p, logic [5:0] k); return {8'h96, k[5:4], 2'(p), k[3:0]}; endfunction

  task automatic ldi(int d, logic [7:0] k); issue(e_ldi(d, k)); m[d] = k; endtask
  task automatic ori(int d, logic [7:0] k); issue(e_ori(d, k)); m[d] = m[d] | k; mz = (m[d] == 0); endtask
  task automatic add(int d, int r);
    logic [8:0] s;
    s = {1'b0, m[d]} + {1'b0, m[r]};
    issue(e_add(d, r)); m[d] = s[7:0]; mc = s[8]; mz = (s[7:0] == 0);
  endtask
  task automatic andr(int d, int r); issue(e_and(d, r)); m[d] = m[d] & m[r]; mz = (m[d] == 0); endtask
  task automatic com(int d); issue(e_com(d)); m[d] = ~m[d]; mc = 1; mz = (m[d] == 0); endtask
  task automatic rol(int d);
    logic c;
    c = m[d][7];
    issue(e_rol(d)); m[d] = {m[d][6:0], mc}; mc = c; mz = (m[d] == 0);
  endtask
  task automatic adiw(int p, logic [5:0] k);
    logic [16:0] s;
    int lo;
    lo = 24 + 2 * p;
    s = {1'b0, m[lo+1], m[lo]} + 17'(k);
    issue(e_adiw(p, k)); m[lo] = s[7:0]; m[lo+1] = s[15:8]; mc = s[16]; mz = (s[15:0] == 0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 32; i++) m[i] = 0;
    mc = 0; mz = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk_flags("R1");
    chk("R1 dbg", dbg_data, 0);
    for (int i = 0; i < 32; i++) chk_reg("R1", i);

    // R4 byte-immediate loads over the whole upper half
    for (int d = 16; d < 32; d++) begin
      ldi(d, 8'(d * 37 + 5));
      chk_flags("R5 ldi");
    end
    for (int d = 16; d < 32; d++) chk_reg("R4", d);
    for (int k = 0; k < 256; k += 51) begin
      ldi(22, 8'(k ^ 8'h0F)); ori(22, 8'(k));
      chk_flags("R5 ori");
      chk_reg("R4 ori", 22);
    end
    ldi(23, 0); ori(23, 0);
    chk_flags("R5 ori zero");

    // R2 add and AND sweeps
    for (int a = 0; a < 256; a += 15)
      for (int b = 0; b < 256; b += 23) begin
        ldi(16, 8'(a)); ldi(17, 8'(b)); add(16, 17);
        chk_flags("R2 add");
        chk_reg("R2 add", 16);
        ldi(18, 8'(a)); andr(18, 17);
        chk_flags("R2 and");
        chk_reg("R2 and", 18);
      end
    ldi(16, 8'h80); ldi(17, 8'h80); add(16, 17);
    chk_flags("R2 add wrap");

    // Lower-half registers via add from a zeroed register, then single-register ops
    ldi(31, 0);
    for (int d = 0; d < 16; d++) begin
      andr(d, 31); ldi(30, 8'(d * 29 + 200)); add(d, 30);
      com(d);
      chk_flags("R3 com");
      chk_reg("R3 com", d);
      rol(d);
      chk_flags("R3 rol");
      chk_reg("R3 rol", d);
      rol(d);
      chk_flags("R3 rol2");
    end
    ldi(20, 8'hFF); com(20);
    chk_flags("R3 com zero");
    ldi(20, 8'h80); ldi(21, 0); add(21, 21); rol(20);
    chk_flags("R3 rol zero");
    chk_reg("R3 rol zero", 20);

    // R6 word add on every pair, with carry and wrap to zero
    for (int p = 0; p < 4; p++)
      for (int base = 0; base < 65536; base += 13107) begin
        for (int k = 0; k < 64; k += 21) begin
          ldi(24 + 2 * p, 8'(base)); ldi(25 + 2 * p, 8'(base >> 8));
          adiw(p, 6'(k));
          chk_flags("R6");
          chk_reg("R6 lo", 24 + 2 * p);
          chk_reg("R6 hi", 25 + 2 * p);
        end
      end
    ldi(28, 8'hC1); ldi(29, 8'hFF); adiw(2, 6'd63);
    chk_flags("R6 wrap");
    chk_reg("R6 wrap", 28); chk_reg("R6 wrap", 29);
    ldi(30, 8'hF0); ldi(31, 8'h12); adiw(3, 6'd16);
    chk_flags("R6 byte carry");
    chk_reg("R6 byte carry", 30); chk_reg("R6 byte carry", 31);

    // R7 unrecognised words
    com(5);
    for (int i = 0; i < 6; i++) begin
      logic [15:0] w;
      case (i)
        0: w = 16'h0000; 1: w = 16'hFFFF; 2: w = 16'h9401;
        3: w = 16'h940F; 4: w = 16'h1234; default: w = 16'h0400;
      endcase
      issue(w);
      chk_flags("R7");
    end
    for (int i = 0; i < 32; i++) chk_reg("R7", i);

    // R8 valid low
    issue(e_ldi(19, 8'h3C), 1'b0);
    issue(e_com(2), 1'b0);
    issue(e_adiw(1, 6'd9), 1'b0);
    chk_flags("R8");
    chk_reg("R8", 19); chk_reg("R8", 2); chk_reg("R8", 26); chk_reg("R8", 27);

    // R9 debug read colliding with a write-back
    ldi(20, 8'h11);
    @(negedge clk);
    dbg_addr = 5'd20; instr = e_ldi(20, 8'h5A); instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    chk("R9 old value", dbg_data, 8'h11);
    @(negedge clk);
    chk("R9 new value", dbg_data, 8'h5A);

    finish_up();
  end
endmodule